// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Shared Reset/Event Pin

This block is the serial test and debug entry point of a chip. An external tester drives a test clock, a mode-select line and a serial data input. A sixteen-state controller steps through capture, shift and update phases for either the instruction register or a data register. The latched instruction chooses which data register sits between the serial input and the serial output. The choices are a one-bit bypass stage, a 32-bit identification word, a boundary chain, or a serial path out to an on-chip debug module. The serial output changes on the falling test-clock edge. Its output enable is high only while a register is being shifted.

One chip pin carries two roles, selected by bit 14 of the debug control register (input `pin_mode_out`). When that bit is 0, the pin is the active-low asynchronous reset of the access port. When the bit is 1, the block drives the pin with an active-low debug-event flag. In that mode the pin level cannot reset the port. A power-on reset (`sys_rst_n`) also resets the port. Every reset is applied at once and is released in step with the test clock.

Top module: `jtag_tap_shared_pin`

## Requirements
- R1: `tms` and `tdi` are sampled on the rising edge of `tck`. `tdo` and `tdo_oe` change only on the falling edge of `tck`.
- R2: `tdo_oe` is 1 exactly while the controller is in Shift-IR or Shift-DR, and is 0 in every other state and during reset.
- R3: The controller implements the sixteen standard states. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state, including Shift-DR and Pause-IR.
- R4: The instruction register is 4 bits wide and shifts LSB first. In Capture-IR it loads 0b0001. Reset and Test-Logic-Reset load the identification code 0b0010.
- R5: Instruction decode: 0b0010 selects identification, 0b0000 selects the boundary chain, 0b0111 selects the debug path, and 0b1111 and every other code select bypass.
- R6: The bypass register is one bit. It captures 0, so a scan returns 0 followed by `tdi` delayed by one clock.
- R7: The identification register is 32 bits. It captures the ID_VALUE parameter with bit 0 forced to 1 and shifts out LSB first.
- R8: The boundary chain captures `bsr_pi` and shifts LSB first. `bsr_po` changes only on the falling edge in Update-DR while the boundary chain is selected.
- R9: `ir_q` changes only on the falling edge in Update-IR or Test-Logic-Reset. It holds its value while a new instruction is being shifted.
- R10: With the debug instruction, `dbg_sel` is 1, `dbg_tdi` follows `tdi`, `dbg_shift` is 1 in Shift-DR, and `tdo` carries `dbg_tdo`.
- R11: With `pin_mode_out`=0, `rst_ev_oe`=0 and a low `rst_ev_in` resets the port at once. With `pin_mode_out`=1, `rst_ev_oe`=1 and `rst_ev_out` equals the inverse of `dbg_event`.
- R12: While `pin_mode_out`=1, a low `rst_ev_in` has no effect on the port.
- R13: `sys_rst_n` low resets the port asynchronously. Release takes effect after two rising edges of `tck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| sys_rst_n | input | 1 | Power-on reset, active low |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Output enable for the `tdo` pad |
| pin_mode_out | input | 1 | Bit 14 of the debug control register: 1 = the shared pin is an event output |
| dbg_event | input | 1 | Debug event from the debug module |
| rst_ev_in | input | 1 | Level seen on the shared pin |
| rst_ev_out | output | 1 | Value driven on the shared pin (active-low event) |
| rst_ev_oe | output | 1 | Output enable for the shared pin |
| dbg_sel | output | 1 | Debug path selected by the instruction |
| dbg_shift | output | 1 | Debug path shift enable |
| dbg_tdi | output | 1 | Serial data to the debug module |
| dbg_tdo | input | 1 | Serial data from the debug module |
| bsr_pi | input | BSR_W | Values captured into the boundary chain |
| bsr_po | output | BSR_W | Updated boundary chain outputs |
| ir_q | output | 4 | Active instruction |

## Verification
The bench reads the identification word right after reset with no instruction load, which checks the reset instruction and the forced bit 0. It then loads the bypass code and an unused code and shifts an irregular bit pattern; the one-clock delay and the leading 0 separate bypass from any longer register. A boundary scan swaps two different bytes, and a later identification scan must leave the boundary outputs unchanged. A debug scan against a model with a known preload shows both the routing out and the routing back. Reset by five ones from Shift-DR and from Pause-IR, a partial instruction shift, and the two pin modes with the pin held low cover the ordering and reset cases.

// File: rtl/jtag_tap_pkg.sv
`timescale 1ns/1ps
package jtag_tap_pkg;
  localparam int IR_W = 4;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_BOUNDARY = 4'b0000;
  localparam logic [IR_W-1:0] OP_IDCODE   = 4'b0010;
  localparam logic [IR_W-1:0] OP_DEBUG    = 4'b0111;
  localparam logic [IR_W-1:0] OP_BYPASS   = 4'b1111;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUNDARY, DR_DEBUG} dr_sel_e;

  function automatic dr_sel_e decode_op(input logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:   return DR_IDENT;
      OP_BOUNDARY: return DR_BOUNDARY;
      OP_DEBUG:    return DR_DEBUG;
      default:     return DR_BYPASS;
    endcase
  endfunction
endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;
  end
endmodule

// File: rtl/jtag_tap_ir.sv
`timescale 1ns/1ps
module jtag_tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic            ir_so,
  output logic [IR_W-1:0] ir_q
);
  logic [IR_W-1:0] sr_q;
  logic cap_en, sh_en, upd_en, rst_en;

  assign cap_en = (state == ST_CAP_IR);
  assign sh_en  = (state == ST_SH_IR);
  assign upd_en = (state == ST_UPD_IR);
  assign rst_en = (state == ST_RESET);
  assign ir_so  = sr_q[0];

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (cap_en) sr_q <= IR_CAPTURE;
    else if (sh_en)  sr_q <= {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      ir_q <= OP_IDCODE;
    else if (rst_en) ir_q <= OP_IDCODE;
    else if (upd_en) ir_q <= sr_q;
  end
endmodule

// File: rtl/jtag_tap_dr.sv
`timescale 1ns/1ps
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int              BSR_W    = 8,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h5B3C_9E2D
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tdi,
  input  tap_state_e       state,
  input  dr_sel_e          sel,
  input  logic [BSR_W-1:0] bsr_pi,
  input  logic             dbg_tdo,
  output logic             dr_so,
  output logic [BSR_W-1:0] bsr_po
);
  localparam logic [ID_W-1:0] ID_CAPT = {ID_VALUE[ID_W-1:1], 1'b1};

  logic             byp_q;
  logic [ID_W-1:0]  id_q;
  logic [BSR_W-1:0] bsr_q, bsr_shifted;
  logic cap_en, sh_en, upd_en;

  assign cap_en = (state == ST_CAP_DR);
  assign sh_en  = (state == ST_SH_DR);
  assign upd_en = (state == ST_UPD_DR) && (sel == DR_BOUNDARY);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                             byp_q <= 1'b0;
    else if (cap_en && sel == DR_BYPASS)    byp_q <= 1'b0;
    else if (sh_en && sel == DR_BYPASS)     byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                             id_q <= '0;
    else if (cap_en && sel == DR_IDENT)     id_q <= ID_CAPT;
    else if (sh_en && sel == DR_IDENT)      id_q <= {tdi, id_q[ID_W-1:1]};
  end

  generate
    if (BSR_W > 1) begin : g_chain
      assign bsr_shifted = {tdi, bsr_q[BSR_W-1:1]};
    end else begin : g_single
      assign bsr_shifted = tdi;
    end
  endgenerate

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                             bsr_q <= '0;
    else if (cap_en && sel == DR_BOUNDARY)  bsr_q <= bsr_pi;
    else if (sh_en && sel == DR_BOUNDARY)   bsr_q <= bsr_shifted;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      bsr_po <= '0;
    else if (upd_en) bsr_po <= bsr_q;
  end

  always_comb begin
    case (sel)
      DR_IDENT:    dr_so = id_q[0];
      DR_BOUNDARY: dr_so = bsr_q[0];
      DR_DEBUG:    dr_so = dbg_tdo;
      default:     dr_so = byp_q;
    endcase
  end
endmodule

// File: rtl/jtag_tap_shared_pin.sv
`timescale 1ns/1ps
module jtag_tap_shared_pin
  import jtag_tap_pkg::*;
#(
  parameter int              BSR_W    = 8,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h5B3C_9E2D
) (
  input  logic             tck,
  input  logic             sys_rst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic             pin_mode_out,
  input  logic             dbg_event,
  input  logic             rst_ev_in,
  output logic             rst_ev_out,
  output logic             rst_ev_oe,
  output logic             dbg_sel,
  output logic             dbg_shift,
  output logic             dbg_tdi,
  input  logic             dbg_tdo,
  input  logic [BSR_W-1:0] bsr_pi,
  output logic [BSR_W-1:0] bsr_po,
  output logic [IR_W-1:0]  ir_q
);
  // Shared pin: reset input in mode 0, event output in mode 1.
  logic trst_raw_n, tap_rst_n;
  logic [1:0] rst_sync_q;

  assign trst_raw_n = sys_rst_n & (pin_mode_out | rst_ev_in);
  assign rst_ev_oe  = pin_mode_out;
  assign rst_ev_out = ~dbg_event;

  always_ff @(posedge tck or negedge trst_raw_n) begin
    if (!trst_raw_n) rst_sync_q <= 2'b00;
    else             rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign tap_rst_n = rst_sync_q[1];

  tap_state_e tap_state;
  dr_sel_e    dr_sel;
  logic       ir_so, dr_so;

  jtag_tap_fsm u_fsm (
    .tck(tck), .rst_n(tap_rst_n), .tms(tms), .state(tap_state)
  );

  jtag_tap_ir u_ir (
    .tck(tck), .rst_n(tap_rst_n), .tdi(tdi), .state(tap_state),
    .ir_so(ir_so), .ir_q(ir_q)
  );

  assign dr_sel = decode_op(ir_q);

  jtag_tap_dr #(.BSR_W(BSR_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst_n(tap_rst_n), .tdi(tdi), .state(tap_state), .sel(dr_sel),
    .bsr_pi(bsr_pi), .dbg_tdo(dbg_tdo), .dr_so(dr_so), .bsr_po(bsr_po)
  );

  assign dbg_sel   = (dr_sel == DR_DEBUG);
  assign dbg_shift = dbg_sel && (tap_state == ST_SH_DR);
  assign dbg_tdi   = tdi;

  // Serial output and its enable are retimed to the falling edge.
  logic tdo_d, oe_d;
  assign tdo_d = (tap_state == ST_SH_IR) ? ir_so : dr_so;
  assign oe_d  = (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);

  always_ff @(negedge tck or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= oe_d;
    end
  end
endmodule

// File: rtl/jtag_tap_shared_pin_chk.sv
`timescale 1ns/1ps
module jtag_tap_shared_pin_chk
  import jtag_tap_pkg::*;
#(
  parameter int BSR_W = 8
) (
  input logic             tck,
  input logic             sys_rst_n,
  input logic             tap_rst_n,
  input logic             tms,
  input logic             pin_mode_out,
  input tap_state_e       state,
  input logic [IR_W-1:0]  ir_q,
  input logic [BSR_W-1:0] bsr_po,
  input logic             tdo_oe
);
  logic [2:0] ones_q;

  always_ff @(posedge tck or negedge tap_rst_n) begin
    if (!tap_rst_n)       ones_q <= 3'd0;
    else if (!tms)        ones_q <= 3'd0;
    else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
  end

  // R2: enable set on the falling edge matches the state held during it
  a_r2_oe_in_shift: assert property (@(posedge tck) disable iff (!tap_rst_n)
    tdo_oe == ((state == ST_SH_IR) || (state == ST_SH_DR)));

  // R3: five ones always land in Test-Logic-Reset
  a_r3_five_ones: assert property (@(posedge tck) disable iff (!tap_rst_n)
    (ones_q >= 3'd5) |-> (state == ST_RESET));

  // R9: instruction output holds outside Update-IR and Test-Logic-Reset
  a_r9_ir_hold: assert property (@(posedge tck) disable iff (!tap_rst_n)
    !((state == ST_UPD_IR) || (state == ST_RESET)) |-> $stable(ir_q));

  // R8: boundary outputs hold outside Update-DR
  a_r8_bsr_hold: assert property (@(posedge tck) disable iff (!tap_rst_n)
    (state != ST_UPD_DR) |-> $stable(bsr_po));

  // R12: output mode held for three edges leaves the port out of reset
  a_r12_pin_no_reset: assert property (@(posedge tck) disable iff (!sys_rst_n)
    (pin_mode_out && $past(pin_mode_out) && $past(pin_mode_out, 2) &&
     $past(sys_rst_n) && $past(sys_rst_n, 2)) |-> tap_rst_n);
endmodule

bind jtag_tap_shared_pin jtag_tap_shared_pin_chk #(.BSR_W(BSR_W)) u_chk (
  .tck(tck), .sys_rst_n(sys_rst_n), .tap_rst_n(tap_rst_n), .tms(tms),
  .pin_mode_out(pin_mode_out), .state(tap_state), .ir_q(ir_q),
  .bsr_po(bsr_po), .tdo_oe(tdo_oe)
);

// File: tb/jtag_tap_shared_pin_bench.sv
`timescale 1ns/1ps
module jtag_tap_shared_pin_bench;
  localparam int          BSR_W  = 8;
  localparam logic [31:0] ID_VAL = 32'h5B3C_9E2D;

  logic tck, sys_rst_n, tms, tdi, tdo, tdo_oe;
  logic pin_mode_out, dbg_event, rst_ev_in, rst_ev_out, rst_ev_oe;
  logic dbg_sel, dbg_shift, dbg_tdi, dbg_tdo;
  logic [BSR_W-1:0] bsr_pi, bsr_po;
  logic [3:0] ir_q;

  int   n_checks = 0, n_errs = 0;
  logic mon_on = 1'b0;
  bit   done = 1'b0;
  logic  exp_q[$];
  string tag_q[$];
  logic [7:0] dbg_model;

  jtag_tap_shared_pin #(.BSR_W(BSR_W), .ID_VALUE(ID_VAL)) u_jtag_tap_shared_pin (
    .tck(tck), .sys_rst_n(sys_rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_mode_out(pin_mode_out), .dbg_event(dbg_event), .rst_ev_in(rst_ev_in),
    .rst_ev_out(rst_ev_out), .rst_ev_oe(rst_ev_oe), .dbg_sel(dbg_sel),
    .dbg_shift(dbg_shift), .dbg_tdi(dbg_tdi), .dbg_tdo(dbg_tdo),
    .bsr_pi(bsr_pi), .bsr_po(bsr_po), .ir_q(ir_q)
  );

  initial tck = 1'b0;
  always #2.5 tck = ~tck;

  // Debug module model: 8-bit shifter preloaded with A5.
  always @(posedge tck or negedge sys_rst_n) begin
    if (!sys_rst_n)     dbg_model <= 8'hA5;
    else if (dbg_shift) dbg_model <= {dbg_tdi, dbg_model[7:1]};
  end
  assign dbg_tdo = dbg_model[0];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each shifted bit is compared with the queued value.
  always @(posedge tck) begin
    logic  e;
    string t;
    if (mon_on && !done) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", 64'(tdo), 64'hx);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check((tdo === e) && (tdo_oe === 1'b1), t, {62'd0, tdo_oe, tdo}, {62'd0, 1'b1, e});
      end
    end
  end

  task automatic step(input logic m, input logic s, input logic d);
    mon_on = m; tms = s; tdi = d;
    @(posedge tck); @(negedge tck); #0.5;
    mon_on = 1'b0;
  endtask

  task automatic push(input logic v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] expv, input string tag);
    for (int i = 0; i < n; i++) push(expv[i], tag);
    step(0, 1, 0); step(0, 0, 0); step(0, 0, 0);
    for (int i = 0; i < n; i++) step(1, i == n - 1, din[i]);
    step(0, 1, 0); step(0, 0, 0);
  endtask

  task automatic scan_ir(input logic [3:0] op, input string tag);
    for (int i = 0; i < 4; i++) push(4'b0001 >> i, tag);
    step(0, 1, 0); step(0, 1, 0); step(0, 0, 0); step(0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, i == 3, op[i]);
    step(0, 1, 0); step(0, 0, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    n_checks++; n_errs++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    sys_rst_n = 0; tms = 1; tdi = 0; pin_mode_out = 0; dbg_event = 0;
    rst_ev_in = 1; bsr_pi = 8'h5A;
    repeat (3) @(negedge tck);
    #0.5;
    check(tdo_oe === 1'b0, "R13 R2 reset oe", 64'(tdo_oe), 0);
    check(ir_q === 4'b0010, "R13 R4 reset ir", 64'(ir_q), 64'h2);
    check(rst_ev_oe === 1'b0, "R11 reset pin dir", 64'(rst_ev_oe), 0);
    sys_rst_n = 1;
    step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
    step(0, 0, 0);
    check(tdo_oe === 1'b0, "R2 idle oe", 64'(tdo_oe), 0);

    // Identification read with the reset instruction
    scan_dr(32, 64'h0, 64'(ID_VAL), "R7 idcode");

    // Bypass code
    scan_ir(4'b1111, "R4 ir capture");
    check(ir_q === 4'b1111, "R5 bypass load", 64'(ir_q), 64'hF);
    scan_dr(6, 64'b101101, {58'd0, 5'b01101, 1'b0}, "R6 R1 bypass");

    // Unused code behaves as bypass
    scan_ir(4'b0101, "R4 ir capture 2");
    scan_dr(5, 64'b10011, {59'd0, 4'b0011, 1'b0}, "R5 unused bypass");

    // R9: instruction holds during a partial shift
    step(0, 1, 0); step(0, 1, 0); step(0, 0, 0); step(0, 0, 0);
    step(0, 0, 0); step(0, 0, 1);
    check(ir_q === 4'b0101, "R9 ir mid shift", 64'(ir_q), 64'h5);
    step(0, 0, 1); step(0, 1, 0);
    check(ir_q === 4'b0101, "R9 ir in exit1", 64'(ir_q), 64'h5);
    step(0, 1, 0);
    check(ir_q === 4'b0110, "R9 ir after update", 64'(ir_q), 64'h6);
    step(0, 0, 0);

    // R1: tdo changes on the falling edge only (bypass, tdi=1)
    step(0, 1, 0); step(0, 0, 0); step(0, 0, 0);
    tms = 0; tdi = 1;
    @(posedge tck); #0.5;
    check(tdo === 1'b0, "R1 tdo held after rising", 64'(tdo), 0);
    @(negedge tck); #0.5;
    check(tdo === 1'b1, "R1 tdo after falling", 64'(tdo), 1);
    step(0, 1, 0); step(0, 1, 0); step(0, 0, 0);

    // Boundary chain
    scan_ir(4'b0000, "R4 ir capture 3");
    scan_dr(8, 64'hC3, 64'h5A, "R8 boundary capture");
    check(bsr_po === 8'hC3, "R8 boundary update", 64'(bsr_po), 64'hC3);
    scan_ir(4'b0010, "R4 ir capture 4");
    scan_dr(32, 64'h0, 64'(ID_VAL), "R7 idcode again");
    check(bsr_po === 8'hC3, "R8 no update when unselected", 64'(bsr_po), 64'hC3);

    // Debug path
    scan_ir(4'b0111, "R4 ir capture 5");
    check(dbg_sel === 1'b1, "R10 dbg_sel", 64'(dbg_sel), 1);
    scan_dr(8, 64'h3C, 64'hA5, "R10 debug tdo");
    check(dbg_model === 8'h3C, "R10 debug tdi", 64'(dbg_model), 64'h3C);

    // R3: five ones from Shift-DR
    step(0, 1, 0); step(0, 0, 0); step(0, 0, 0);
    repeat (5) step(0, 1, 0);
    check(ir_q === 4'b0010, "R3 reset from shift-dr", 64'(ir_q), 64'h2);
    check(tdo_oe === 1'b0, "R3 R2 oe after reset", 64'(tdo_oe), 0);
    step(0, 0, 0);
    // R3: five ones from Pause-IR
    scan_ir(4'b1111, "R4 ir capture 6");
    step(0, 1, 0); step(0, 1, 0); step(0, 0, 0); step(0, 0, 0);
    step(0, 0, 1); step(0, 1, 1); step(0, 0, 0);
    repeat (5) step(0, 1, 0);
    check(ir_q === 4'b0010, "R3 reset from pause-ir", 64'(ir_q), 64'h2);
    step(0, 0, 0);

    // Shared pin in output mode
    pin_mode_out = 1; dbg_event = 1; #0.5;
    check(rst_ev_oe === 1'b1, "R11 pin drives", 64'(rst_ev_oe), 1);
    check(rst_ev_out === 1'b0, "R11 event low", 64'(rst_ev_out), 0);
    dbg_event = 0; #0.5;
    check(rst_ev_out === 1'b1, "R11 no event high", 64'(rst_ev_out), 1);
    scan_ir(4'b1111, "R4 ir capture 7");
    rst_ev_in = 0;
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    check(ir_q === 4'b1111, "R12 pin low ignored", 64'(ir_q), 64'hF);
    scan_dr(3, 64'b011, {61'd0, 2'b11, 1'b0}, "R12 tap alive");

    // Shared pin back to input mode while low: immediate reset
    pin_mode_out = 0; #1;
    check(ir_q === 4'b0010, "R11 pin reset", 64'(ir_q), 64'h2);
    check(rst_ev_oe === 1'b0, "R11 pin input", 64'(rst_ev_oe), 0);
    rst_ev_in = 1;
    @(negedge tck); #0.5;
    step(0, 1, 0); step(0, 1, 0); step(0, 0, 0);

    check(exp_q.size() == 0, "scoreboard drained", 64'(exp_q.size()), 0);
    finish_run();
  end
endmodule